// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM built around a two-stage pipeline. On every enabled clock it takes one command, either a read or a write, together with its address. Reads and writes can be mixed on consecutive clocks, and the shared data bus never needs idle cycles between them. Read data appears on the bus two enabled clocks after its command. Write data is taken from the bus two enabled clocks after its command. Because reads and writes share the same lag, the bus direction can change from one cycle to the next.

A low-active clock enable freezes the whole pipeline, including read data that is already on the bus. An advance input continues a burst from the last loaded address, stepping through a group of four words. Three chip-select inputs gate new loads. The bidirectional bus is split into a write-data input, a read-data output and a drive flag. Words are `LANES` lanes of `LANE_W` bits, and there are `2**ADDR_W` words. Setting `ADDR_W` to 17 gives 128K words of 36 bits. The default is kept smaller for elaboration.

Top module: `zbt_sram_pipe`

## Requirements
- R1: A synchronous active-high `rst` clears every pipeline valid flag and the burst state, so `rdata_drive` is low on the cycle after the reset edge. Memory contents are kept across reset, and reset acts whether or not the clock is enabled.
- R2: A load read is accepted on an enabled edge when `burst_adv`=0, `rw_sel`=1 and the chip is selected. Its word is on `rdata` and marked valid after the second enabled edge following the command edge.
- R3: A load write uses the same conditions with `rw_sel`=0. It latches `lane_wr_n` with the command. On the second enabled edge after the command it stores `wdata` bits [LANE_W*i+LANE_W-1 : LANE_W*i] only for the lanes i whose `lane_wr_n[i]` was 0.
- R4: The chip is selected only when `sel0_n`=0, `sel1_n`=0 and `sel2`=1. A load with any one of these violated issues no operation.
- R5: While `clk_en_n`=1, rising edges change nothing. No command is taken, no write is committed, and `rdata` and `rdata_drive` hold.
- R6: Commands on consecutive enabled edges, in any mix of reads and writes, produce their read data in command order on consecutive enabled cycles.
- R7: `rdata_drive` is high exactly when `out_en_n`=0 and the pipeline holds a valid read word for the current cycle.
- R8: With `burst_adv`=1 on an enabled edge after a selected load, the block repeats the loaded operation type. The next address keeps the upper address bits and adds one to the low two bits, wrapping within the group of four. The chip selects are ignored on such edges, and the byte enables are taken from the current cycle. An advance after a deselected load, or after reset, issues no operation.
- R9: A deselected or advance-without-burst cycle moves an empty slot through the pipeline, so nothing is driven two enabled cycles later.
- R10: A read issued one enabled cycle after a write to the same address returns the newly written lanes. The new lanes are forwarded from the committing write, and the old word supplies the lanes that were not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock enable, active low; high freezes the block |
| addr | input | ADDR_W | Word address for load commands |
| rw_sel | input | 1 | 1 = read, 0 = write (load commands) |
| burst_adv | input | 1 | 1 = continue burst, 0 = load new address |
| sel0_n | input | 1 | Chip select, active low |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| out_en_n | input | 1 | Output enable, active low |
| wdata | input | LANES*LANE_W | Write data, sampled two enabled edges after a write command |
| rdata | output | LANES*LANE_W | Read data |
| rdata_drive | output | 1 | High when the block drives the bus |

## Verification
The bench builds the block with `ADDR_W` set to 4 and with 4 lanes of 9 bits. A 16-word array can be filled completely in a short preamble, so every later read has a known value. Random addresses then hit the same word often, which makes write-then-read forwarding and partial lane writes over older data routine events rather than rare ones. With only four burst groups, wrap-around from the top of a group to its bottom occurs many times in the random phase, on top of the directed bursts.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

  typedef enum logic {
    OP_WR = 1'b0,
    OP_RD = 1'b1
  } op_e;

  // Combined chip select: two low-active selects and one high-active select.
  function automatic logic chip_selected(input logic s0_n, input logic s1_n,
                                         input logic s2);
    return (~s0_n) & (~s1_n) & s2;
  endfunction

  // Burst counter step, wraps inside a group of four words.
  function automatic logic [1:0] wrap_step(input logic [1:0] cnt);
    return cnt + 2'd1;
  endfunction

endpackage

// File: rtl/zbt_issue.sv
// Command issue: decodes a load or a burst advance into a pipeline command.
module zbt_issue
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rw_sel,
  input  logic              burst_adv,
  input  logic              sel0_n,
  input  logic              sel1_n,
  input  logic              sel2,
  input  logic [LANES-1:0]  lane_wr_n,
  output logic              cmd_vld,
  output op_e               cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LANES-1:0]  cmd_be
);

  localparam int HI_W = ADDR_W - 2;

  logic            burst_on;
  op_e             burst_op;
  logic [HI_W-1:0] base_hi;
  logic [1:0]      burst_cnt;
  logic            selected;
  logic [1:0]      next_cnt;

  assign selected = chip_selected(sel0_n, sel1_n, sel2);
  assign next_cnt = wrap_step(burst_cnt);

  always_comb begin
    cmd_be = ~lane_wr_n;
    if (burst_adv) begin
      cmd_vld  = burst_on;
      cmd_op   = burst_op;
      cmd_addr = {base_hi, next_cnt};
    end else begin
      cmd_vld  = selected;
      cmd_op   = rw_sel ? OP_RD : OP_WR;
      cmd_addr = addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_on  <= 1'b0;
      burst_op  <= OP_RD;
      base_hi   <= '0;
      burst_cnt <= '0;
    end else if (en) begin
      if (!burst_adv) begin
        burst_on  <= selected;
        burst_op  <= rw_sel ? OP_RD : OP_WR;
        base_hi   <= addr[ADDR_W-1:2];
        burst_cnt <= addr[1:0];
      end else if (burst_on) begin
        burst_cnt <= next_cnt;
      end
    end
  end

endmodule

// File: rtl/zbt_store.sv
// Word array with lane writes and a registered read that forwards the
// lanes of a write committing on the same edge.
module zbt_store #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    en,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_be,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANES*LANE_W-1:0] rd_q,
  output logic                    fwd_hit
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [LANES-1:0]  fwd_be;

  function automatic logic [DATA_W-1:0] merge_lanes(
      input logic [DATA_W-1:0] old_w, input logic [DATA_W-1:0] new_w,
      input logic [LANES-1:0] be);
    logic [DATA_W-1:0] res;
    res = old_w;
    for (int i = 0; i < LANES; i++)
      if (be[i]) res[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
    return res;
  endfunction

  assign fwd_hit = we && (wr_addr == rd_addr);
  assign fwd_be  = fwd_hit ? wr_be : '0;

  always_ff @(posedge clk) begin
    if (we) mem[wr_addr] <= merge_lanes(mem[wr_addr], wr_data, wr_be);
  end

  always_ff @(posedge clk) begin
    if (en) rd_q <= merge_lanes(mem[rd_addr], wr_data, fwd_be);
  end

endmodule

// File: rtl/zbt_out_stage.sv
// Output register and bus drive control.
module zbt_out_stage #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              load_vld,
  input  logic [DATA_W-1:0] load_data,
  input  logic              out_en_n,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_drive,
  output logic              out_vld
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
    end else if (en) begin
      out_vld <= load_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (en && load_vld) rdata <= load_data;
  end

  assign rdata_drive = out_vld & ~out_en_n;

endmodule

// File: rtl/zbt_sram_pipe.sv
// Top: issue stage, two pipeline stages, word array and output register.
module zbt_sram_pipe
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clk_en_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    rw_sel,
  input  logic                    burst_adv,
  input  logic                    sel0_n,
  input  logic                    sel1_n,
  input  logic                    sel2,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    out_en_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_drive
);

  localparam int DATA_W = LANES * LANE_W;

  logic              en;
  logic              cmd_vld;
  op_e               cmd_op;
  logic [ADDR_W-1:0] cmd_addr;
  logic [LANES-1:0]  cmd_be;

  logic              s1_vld, s2_vld;
  op_e               s1_op, s2_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [LANES-1:0]  s1_be, s2_be;

  logic              mem_we;
  logic              fwd_hit;
  logic              out_vld;
  logic              rd_load;
  logic [DATA_W-1:0] rd_q;

  assign en = ~clk_en_n;

  zbt_issue #(.ADDR_W(ADDR_W), .LANES(LANES)) u_issue (
    .clk(clk), .rst(rst), .en(en), .addr(addr), .rw_sel(rw_sel),
    .burst_adv(burst_adv), .sel0_n(sel0_n), .sel1_n(sel1_n), .sel2(sel2),
    .lane_wr_n(lane_wr_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_be(cmd_be)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      s2_vld <= 1'b0;
    end else if (en) begin
      s1_vld <= cmd_vld;
      s2_vld <= s1_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      s1_op   <= cmd_op;
      s1_addr <= cmd_addr;
      s1_be   <= cmd_be;
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
    end
  end

  assign mem_we  = en && !rst && s2_vld && (s2_op == OP_WR);
  assign rd_load = s2_vld && (s2_op == OP_RD);

  zbt_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk(clk), .en(en), .we(mem_we), .wr_addr(s2_addr), .wr_be(s2_be),
    .wr_data(wdata), .rd_addr(s1_addr), .rd_q(rd_q), .fwd_hit(fwd_hit)
  );

  zbt_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .en(en), .load_vld(rd_load), .load_data(rd_q),
    .out_en_n(out_en_n), .rdata(rdata), .rdata_drive(rdata_drive),
    .out_vld(out_vld)
  );

endmodule

// File: rtl/zbt_sram_chk.sv
// Property checker attached to the top module.
module zbt_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              clk_en_n,
  input logic              burst_adv,
  input logic              sel0_n,
  input logic              sel1_n,
  input logic              sel2,
  input logic              out_en_n,
  input logic [DATA_W-1:0] rdata,
  input logic              rdata_drive,
  input logic              s1_vld,
  input logic              out_vld,
  input logic              mem_we,
  input logic              fwd_hit
);

  // R7: the bus is never driven while output enable is inactive
  p_drive_oe_r7: assert property (@(posedge clk) disable iff (rst)
    rdata_drive |-> !out_en_n);

  // R5: a disabled edge leaves the output and the pipeline unchanged
  p_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    clk_en_n |=> ($stable(rdata) && $stable(out_vld) && $stable(s1_vld)));

  // R1: reset empties the pipeline
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_vld && !s1_vld));

  // R4 and R9: a deselected load leaves an empty slot behind it
  p_deselect_r9: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !burst_adv && (sel0_n || sel1_n || !sel2)) |=> !s1_vld);

  // R3 and R5: no write commits on a disabled edge
  p_commit_en_r3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !clk_en_n);

  // R10: forwarding only happens alongside a write commit
  p_fwd_commit_r10: assert property (@(posedge clk) disable iff (rst)
    fwd_hit |-> mem_we);

endmodule

bind zbt_sram_pipe zbt_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .burst_adv(burst_adv),
  .sel0_n(sel0_n), .sel1_n(sel1_n), .sel2(sel2), .out_en_n(out_en_n),
  .rdata(rdata), .rdata_drive(rdata_drive), .s1_vld(s1_vld),
  .out_vld(out_vld), .mem_we(mem_we), .fwd_hit(fwd_hit)
);

// File: tb/sim_zbt_sram_pipe.sv
`timescale 1ns/1ps
module sim_zbt_sram_pipe;

  localparam int AW    = 4;
  localparam int NL    = 4;
  localparam int LW    = 9;
  localparam int DW    = NL * LW;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clk_en_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          rw_sel = 1'b1;
  logic          burst_adv = 1'b0;
  logic          sel0_n = 1'b1, sel1_n = 1'b0, sel2 = 1'b1;
  logic [NL-1:0] lane_wr_n = '1;
  logic          out_en_n = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          rdata_drive;

  int n_checks = 0;
  int n_fail   = 0;
  string tag = "R1 reset";

  always #10 clk = ~clk;

  zbt_sram_pipe #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u0 (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .addr(addr), .rw_sel(rw_sel),
    .burst_adv(burst_adv), .sel0_n(sel0_n), .sel1_n(sel1_n), .sel2(sel2),
    .lane_wr_n(lane_wr_n), .out_en_n(out_en_n), .wdata(wdata),
    .rdata(rdata), .rdata_drive(rdata_drive)
  );

  // Reference state, written from the requirements.
  logic [DW-1:0] ref_mem [WORDS];
  logic          q_v [2];
  logic          q_rd [2];
  logic [AW-1:0] q_a [2];
  logic [NL-1:0] q_be [2];
  logic          b_act = 1'b0, b_rd = 1'b0;
  logic [AW-1:0] b_base = '0;
  logic [1:0]    b_cnt = '0;
  logic          exp_v = 1'b0;
  logic [DW-1:0] exp_d = '0;

  function automatic logic [DW-1:0] lane_apply(logic [DW-1:0] o,
      logic [DW-1:0] n, logic [NL-1:0] be);
    logic [DW-1:0] r = o;
    for (int i = 0; i < NL; i++)
      if (be[i]) for (int b = 0; b < LW; b++) r[i*LW+b] = n[i*LW+b];
    return r;
  endfunction

  function automatic logic [DW-1:0] rnd_word();
    return {$urandom(), $urandom()};
  endfunction

  // Model one rising edge with the inputs now on the pins.
  task automatic model_edge();
    logic          nv, nrd;
    logic [AW-1:0] na;
    if (rst) begin
      q_v[0] = 0; q_v[1] = 0; exp_v = 0; b_act = 0;
      return;
    end
    if (clk_en_n) return;
    if (q_v[1] && q_rd[1]) exp_d = ref_mem[q_a[1]];
    exp_v = q_v[1] && q_rd[1];
    if (q_v[1] && !q_rd[1]) ref_mem[q_a[1]] = lane_apply(ref_mem[q_a[1]], wdata, q_be[1]);
    q_v[1] = q_v[0]; q_rd[1] = q_rd[0]; q_a[1] = q_a[0]; q_be[1] = q_be[0];
    if (!burst_adv) begin
      nv = (sel0_n == 0) && (sel1_n == 0) && (sel2 == 1);
      nrd = rw_sel; na = addr;
      b_act = nv; b_rd = rw_sel; b_base = addr; b_cnt = addr[1:0];
    end else begin
      nv = b_act; nrd = b_rd;
      b_cnt = b_cnt + 2'd1;
      na = {b_base[AW-1:2], b_cnt};
    end
    q_v[0] = nv; q_rd[0] = nrd; q_a[0] = na; q_be[0] = ~lane_wr_n;
  endtask

  task automatic check_out();
    logic ed;
    ed = exp_v && !out_en_n;
    n_checks++;
    if (rdata_drive !== ed) begin
      n_fail++;
      $display("FAIL %s drive: got %0b expected %0b", tag, rdata_drive, ed);
    end
    if (ed) begin
      n_checks++;
      if (rdata !== exp_d) begin
        n_fail++;
        $display("FAIL %s data: got %h expected %h", tag, rdata, exp_d);
      end
    end
  endtask

  task automatic tick();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    check_out();
  endtask

  task automatic sel_ok();
    sel0_n = 0; sel1_n = 0; sel2 = 1;
  endtask

  task automatic load(logic rd, logic [AW-1:0] a, logic [NL-1:0] wn);
    clk_en_n = 0; burst_adv = 0; rw_sel = rd; addr = a; lane_wr_n = wn;
    sel_ok(); wdata = rnd_word(); tick();
  endtask

  task automatic nop(int n);
    for (int i = 0; i < n; i++) begin
      clk_en_n = 0; burst_adv = 0; sel0_n = 1; wdata = rnd_word(); tick();
    end
  endtask

  task automatic advance(logic [NL-1:0] wn);
    clk_en_n = 0; burst_adv = 1; lane_wr_n = wn; wdata = rnd_word(); tick();
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 2; i++) begin q_v[i] = 0; q_rd[i] = 0; q_a[i] = '0; q_be[i] = '0; end
    @(negedge clk);
    tick(); tick();
    rst = 0;
    // R1: nothing driven after reset
    tag = "R1 reset state";
    n_checks++;
    if (rdata_drive !== 1'b0) begin
      n_fail++; $display("FAIL R1 drive after reset: got %0b expected 0", rdata_drive);
    end
    nop(2);
    // Fill memory (R3 full-word writes)
    tag = "R3 fill";
    for (int a = 0; a < WORDS; a++) load(0, AW'(a), '0);
    nop(2);
    tag = "R2 R6 readback";
    for (int a = 0; a < WORDS; a++) load(1, AW'(a), '1);
    nop(3);
    // R3 lane writes then read
    tag = "R3 lanes";
    load(0, 4'd5, 4'b1010); load(0, 4'd6, 4'b0101); nop(2);
    load(1, 4'd5, '1); load(1, 4'd6, '1); nop(3);
    // R10 write then immediate read of same address
    tag = "R10 forward";
    load(0, 4'd9, 4'b0110); load(1, 4'd9, '1); nop(3);
    load(0, 4'd2, 4'b0000); load(1, 4'd2, '1); load(0, 4'd2, 4'b1000); load(1, 4'd2, '1); nop(3);
    // R6 mixed back to back
    tag = "R6 mixed";
    load(1, 4'd1, '1); load(0, 4'd1, 4'b0011); load(1, 4'd1, '1); load(1, 4'd7, '1); nop(3);
    // R4 each select violated
    tag = "R4 select";
    for (int k = 0; k < 3; k++) begin
      clk_en_n = 0; burst_adv = 0; rw_sel = 1; addr = 4'd3; sel_ok();
      if (k == 0) sel0_n = 1; else if (k == 1) sel1_n = 1; else sel2 = 0;
      tick();
    end
    nop(3);
    // R5 freeze while a read is in flight and on the bus
    tag = "R5 freeze";
    load(1, 4'd4, '1); load(1, 4'd8, '1);
    clk_en_n = 1; sel0_n = 1; tick(); tick(); tick();
    nop(1); clk_en_n = 1; tick(); tick(); nop(3);
    // R7 output enable gating
    tag = "R7 oe";
    load(1, 4'd10, '1); load(1, 4'd11, '1); nop(1);
    out_en_n = 1; nop(1); out_en_n = 0; nop(2);
    // R8 burst wrap from top of group, reads and writes
    tag = "R8 burst";
    load(1, 4'd3, '1); advance('1); advance('1); advance('1); advance('1); nop(3);
    load(0, 4'd14, 4'b0000); advance(4'b1100); advance(4'b0000); nop(2);
    load(1, 4'd12, '1); advance('1); advance('1); advance('1); nop(3);
    // R9 advance after a deselected load is empty
    tag = "R9 empty slot";
    nop(1); advance('1); advance('1); nop(3);
    // R1 memory kept across reset
    tag = "R1 memory kept";
    load(0, 4'd13, 4'b0000); nop(2);
    rst = 1; clk_en_n = 1; tick(); rst = 0;
    nop(1); advance('1); nop(2);
    load(1, 4'd13, '1); nop(3);
    // Random mixed traffic
    tag = "R2 R6 R8 R10 random";
    for (int c = 0; c < 4000; c++) begin
      clk_en_n  = ($urandom_range(0, 9) < 2);
      burst_adv = ($urandom_range(0, 3) == 0);
      rw_sel    = $urandom_range(0, 1);
      addr      = AW'($urandom());
      sel0_n    = ($urandom_range(0, 9) == 0);
      sel1_n    = ($urandom_range(0, 9) == 0);
      sel2      = ($urandom_range(0, 9) != 0);
      lane_wr_n = NL'($urandom());
      out_en_n  = ($urandom_range(0, 6) == 0);
      wdata     = rnd_word();
      tick();
    end
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog %s: got timeout expected completion", tag);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule